// File: doc/BRIEF.md
# Stochastic Integrate-and-Fire Neuron Array

The block is a digital, time-shared model of a large population of integrate-and-fire neurons. Each neuron's membrane potential is kept in one word of a single-port state memory. A synapse command names a target neuron and carries its own parameters with it:

- a 3-bit weight;
- a polarity bit that makes the step excitatory or inhibitory;
- a repeat count;
- an 8-bit delivery probability.

The engine reads the target's potential once. It then applies one delivery attempt per cycle. Each attempt is gated by a pseudo-random test against the probability. After the last attempt the engine writes the potential back.

When an excitatory step brings a potential up to the global threshold, that neuron is reset to zero and its index is pushed as a spike into a small output queue. A system places the block behind an event router. Raising the threshold trades output event rate against sensitivity.

After reset the engine sweeps the whole state memory to zero before it accepts commands. A command that hits the neuron just written back skips the memory read and reuses the held value.

Top module: `spk_array_engine`

## Requirements
- R1: After reset, `in_ready` and `out_valid` stay low while every neuron's potential is cleared to zero, one neuron per cycle. Commands are accepted only after the sweep.
- R2: An excitatory delivery (`in_excite`=1) raises the target's potential by the weight shifted left by STEP_SHIFT (default 2, so weight×4). The sum saturates at the potential maximum.
- R3: An inhibitory delivery (`in_excite`=0) lowers the potential by the same step. The result clamps at zero and never wraps.
- R4: If the potential after an excitatory delivery is greater than or equal to `threshold`, the neuron is reset to zero and one spike carrying the target index appears on `out_addr`.
- R5: A command makes `in_count`+1 delivery attempts, one per cycle, applied in sequence. A single command can therefore fire its neuron several times. `in_ready` is low the cycle after an accept.
- R6: A probability of 255 delivers every attempt and 0 delivers none. Any other value p delivers when the top byte of a 16-bit LFSR is below p. The LFSR uses taps 0xB400 and seed 0xACE1, steps once per attempt, and gives a rate near p/256.
- R7: `threshold` is a global input. Each delivery is compared against its current value.
- R8: When the spike queue (default depth 4) is full, delivery attempts pause and `in_ready` stays low. No spike is lost. A spike held with `out_ready` low keeps its address.
- R9: Back-to-back commands to the same neuron see the potential left by the previous command.
- R10: Neurons are independent. Every index from 0 to 2047 is addressable.
- R11: A weight of 0 leaves the potential unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| threshold | input | 12 | Global firing threshold |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Engine can take a command |
| in_target | input | 11 | Target neuron index |
| in_weight | input | 3 | Synaptic weight |
| in_excite | input | 1 | 1 excitatory, 0 inhibitory |
| in_count | input | 3 | Delivery attempts minus one |
| in_prob | input | 8 | Delivery probability (255 = always) |
| out_valid | output | 1 | Spike available |
| out_ready | input | 1 | Consumer takes the spike |
| out_addr | output | 11 | Index of the neuron that fired |

## Verification
The checker watches the following on every cycle:
- the silence of both handshakes during the clearing sweep;
- that a spike is pushed only while deliveries are running, and never into a full queue;
- that a zero-probability command never produces a spike;
- that a spike being held keeps its address;
- that the engine drops readiness right after an accept.

Only the bench scenarios can show the arithmetic: steps added and subtracted, clamping at zero, firing at the threshold, multiple firings within one repeat loop, and forwarding between consecutive commands. The bench reads these from spike counts and addresses. It also shows the stall that loses no spikes and the statistical delivery rate.

// File: rtl/spk_pkg.sv
package spk_pkg;
   typedef enum logic [2:0] {
      S_CLEAR,
      S_IDLE,
      S_READ,
      S_LOOP,
      S_WRITE
   } state_t;
endpackage

// File: rtl/spk_lfsr.sv
module spk_lfsr #(
   parameter int                 W     = 16,
   parameter int                 OUT_W = 8,
   parameter logic [W-1:0]       TAPS  = 16'hB400,
   parameter logic [W-1:0]       SEED  = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [OUT_W-1:0] top
);
   if (OUT_W > W) begin : g_bad_w
      $error("spk_lfsr: OUT_W exceeds W");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("spk_lfsr: seed must be nonzero");
   end

   logic [W-1:0] state_q;
   logic [W-1:0] state_d;

   // Galois form: shift right, fold taps in when the outgoing bit is set
   always_comb begin
      for (int i = 0; i < W; i++) begin
         if (i == W - 1) state_d[i] = TAPS[i] & state_q[0];
         else            state_d[i] = state_q[i+1] ^ (TAPS[i] & state_q[0]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    state_q <= SEED;
      else if (step) state_q <= state_d;
   end

   assign top = state_q[W-1 -: OUT_W];
endmodule

// File: rtl/spk_potential_ram.sv
module spk_potential_ram #(
   parameter int DEPTH = 2048,
   parameter int DW    = 12,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   // single port: one read or one write per cycle, read data registered
   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/spk_fifo.sv
module spk_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 11,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          valid,
   output logic          full,
   output logic [CW-1:0] count
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("spk_fifo: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] data_q;
      logic         hold_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hold_q <= 1'b0;
            data_q <= '0;
         end else if (push && !hold_q) begin
            hold_q <= 1'b1;
            data_q <= din;
         end else if (pop && hold_q) begin
            hold_q <= 1'b0;
         end
      end
      assign dout  = data_q;
      assign valid = hold_q;
      assign full  = hold_q;
      assign count = CW'(hold_q);
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      if ((1 << PW) != DEPTH) begin : g_bad_pow2
         $error("spk_fifo: DEPTH must be a power of two");
      end
      logic [W-1:0]  mem [DEPTH];
      logic [PW-1:0] wr_q, rd_q;
      logic [CW-1:0] cnt_q;
      logic          do_push, do_pop;

      assign do_push = push && (cnt_q != CW'(DEPTH));
      assign do_pop  = pop && (cnt_q != '0);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (do_push) wr_q <= wr_q + PW'(1);
            if (do_pop)  rd_q <= rd_q + PW'(1);
            case ({do_push, do_pop})
               2'b10:   cnt_q <= cnt_q + CW'(1);
               2'b01:   cnt_q <= cnt_q - CW'(1);
               default: cnt_q <= cnt_q;
            endcase
         end
      end

      always_ff @(posedge clk) begin
         if (do_push) mem[wr_q] <= din;
      end

      assign dout  = mem[rd_q];
      assign valid = (cnt_q != '0);
      assign full  = (cnt_q == CW'(DEPTH));
      assign count = cnt_q;
   end
endmodule

// File: rtl/spk_array_engine.sv
module spk_array_engine
   import spk_pkg::*;
#(
   parameter int NEURONS    = 2048,
   parameter int POT_W      = 12,
   parameter int WGT_W      = 3,
   parameter int CNT_W      = 3,
   parameter int PROB_W     = 8,
   parameter int STEP_SHIFT = 2,
   parameter int FIFO_DEPTH = 4,
   parameter int LFSR_W     = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   localparam int AW = $clog2(NEURONS),
   localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [POT_W-1:0]  threshold,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [AW-1:0]     in_target,
   input  logic [WGT_W-1:0]  in_weight,
   input  logic              in_excite,
   input  logic [CNT_W-1:0]  in_count,
   input  logic [PROB_W-1:0] in_prob,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [AW-1:0]     out_addr
);
   if (WGT_W + STEP_SHIFT > POT_W) begin : g_bad_step
      $error("spk_array_engine: shifted weight wider than potential");
   end
   if (PROB_W > LFSR_W) begin : g_bad_prob
      $error("spk_array_engine: probability wider than LFSR");
   end
   if (NEURONS < 2) begin : g_bad_n
      $error("spk_array_engine: need at least two neurons");
   end

   state_t            state;
   logic [AW-1:0]     clr_addr;
   logic [AW-1:0]     ev_target;
   logic [WGT_W-1:0]  ev_weight;
   logic              ev_excite;
   logic [CNT_W-1:0]  ev_left;
   logic [PROB_W-1:0] ev_prob;
   logic [AW-1:0]     cache_addr;
   logic              cache_valid;
   logic [POT_W-1:0]  acc;
   logic              load_q;

   logic              accept;
   logic              advance;
   logic              hit;
   logic              fire;
   logic              push;
   logic              fifo_full;
   logic [CW-1:0]     fifo_count;
   logic [PROB_W-1:0] rnd_byte;

   logic              ram_en, ram_we;
   logic [AW-1:0]     ram_addr;
   logic [POT_W-1:0]  ram_wdata, ram_rdata;

   logic [POT_W-1:0]  cur, step_amt, up, down, nxt;
   logic [POT_W:0]    sum;

   // ---------------- datapath ----------------
   assign cur      = load_q ? ram_rdata : acc;
   assign step_amt = POT_W'(ev_weight) << STEP_SHIFT;
   assign sum      = {1'b0, cur} + {1'b0, step_amt};
   assign up       = sum[POT_W] ? '1 : sum[POT_W-1:0];
   assign down     = (cur > step_amt) ? (cur - step_amt) : '0;
   assign nxt      = ev_excite ? up : down;

   assign hit      = (ev_prob == '1) || (rnd_byte < ev_prob);
   assign advance  = (state == S_LOOP) && !fifo_full;
   assign fire     = advance && hit && ev_excite && (up >= threshold);
   assign push     = fire;

   assign in_ready = (state == S_IDLE) && !fifo_full;
   assign accept   = in_valid && in_ready;

   // ---------------- state memory port ----------------
   always_comb begin
      ram_en    = 1'b0;
      ram_we    = 1'b0;
      ram_addr  = ev_target;
      ram_wdata = acc;
      case (state)
         S_CLEAR: begin
            ram_en    = 1'b1;
            ram_we    = 1'b1;
            ram_addr  = clr_addr;
            ram_wdata = '0;
         end
         S_READ:  ram_en = 1'b1;
         S_WRITE: begin
            ram_en = 1'b1;
            ram_we = 1'b1;
         end
         default: ram_en = 1'b0;
      endcase
   end

   // ---------------- control ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= S_CLEAR;
         clr_addr    <= '0;
         ev_target   <= '0;
         ev_weight   <= '0;
         ev_excite   <= 1'b0;
         ev_left     <= '0;
         ev_prob     <= '0;
         cache_addr  <= '0;
         cache_valid <= 1'b0;
         acc         <= '0;
         load_q      <= 1'b0;
      end else begin
         case (state)
            S_CLEAR: begin
               clr_addr <= clr_addr + AW'(1);
               if (clr_addr == AW'(NEURONS - 1)) state <= S_IDLE;
            end
            S_IDLE: begin
               if (accept) begin
                  ev_target <= in_target;
                  ev_weight <= in_weight;
                  ev_excite <= in_excite;
                  ev_left   <= in_count;
                  ev_prob   <= in_prob;
                  if (cache_valid && (in_target == cache_addr)) begin
                     load_q <= 1'b0;
                     state  <= S_LOOP;
                  end else begin
                     state  <= S_READ;
                  end
               end
            end
            S_READ: begin
               load_q <= 1'b1;
               state  <= S_LOOP;
            end
            S_LOOP: begin
               if (advance) begin
                  load_q <= 1'b0;
                  if (fire)     acc <= '0;
                  else if (hit) acc <= nxt;
                  else          acc <= cur;
                  if (ev_left == '0) state <= S_WRITE;
                  else               ev_left <= ev_left - CNT_W'(1);
               end
            end
            S_WRITE: begin
               cache_addr  <= ev_target;
               cache_valid <= 1'b1;
               state       <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // ---------------- submodules ----------------
   spk_lfsr #(
      .W     (LFSR_W),
      .OUT_W (PROB_W),
      .TAPS  (LFSR_TAPS),
      .SEED  (LFSR_SEED)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (advance),
      .top   (rnd_byte)
   );

   spk_potential_ram #(
      .DEPTH (NEURONS),
      .DW    (POT_W)
   ) u_ram (
      .clk   (clk),
      .en    (ram_en),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (ram_wdata),
      .rdata (ram_rdata)
   );

   spk_fifo #(
      .DEPTH (FIFO_DEPTH),
      .W     (AW)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (ev_target),
      .pop   (out_ready),
      .dout  (out_addr),
      .valid (out_valid),
      .full  (fifo_full),
      .count (fifo_count)
   );
endmodule

// File: rtl/spk_array_engine_chk.sv
module spk_array_engine_chk
   import spk_pkg::*;
#(
   parameter int AW         = 11,
   parameter int PROB_W     = 8,
   parameter int FIFO_DEPTH = 4,
   parameter int CW         = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [AW-1:0]     out_addr,
   input state_t            state,
   input logic              push,
   input logic [CW-1:0]     fifo_count,
   input logic [PROB_W-1:0] ev_prob
);
   // R1
   clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_CLEAR) |-> (!in_ready && !out_valid));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (fifo_count < CW'(FIFO_DEPTH)));

   // R8
   spike_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

   // R6
   prob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_LOOP) && (ev_prob == '0)) |-> !push);

   // R5
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R4
   fire_in_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (state == S_LOOP));
endmodule

bind spk_array_engine spk_array_engine_chk #(
   .AW         (AW),
   .PROB_W     (PROB_W),
   .FIFO_DEPTH (FIFO_DEPTH),
   .CW         (CW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_addr   (out_addr),
   .state      (state),
   .push       (push),
   .fifo_count (fifo_count),
   .ev_prob    (ev_prob)
);

// File: tb/tb_spk_array_engine.sv
module tb_spk_array_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] threshold = 12'd40;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [10:0] in_target = '0;
   logic [2:0]  in_weight = '0;
   logic        in_excite = 1'b0;
   logic [2:0]  in_count = '0;
   logic [7:0]  in_prob = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [10:0] out_addr;

   int n_chk = 0;
   int n_err = 0;
   int spk_cnt = 0;
   int addr_err = 0;
   logic [10:0] exp_addr = '0;

   always #5 clk = ~clk;

   spk_array_engine dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .threshold (threshold),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_target (in_target),
      .in_weight (in_weight),
      .in_excite (in_excite),
      .in_count  (in_count),
      .in_prob   (in_prob),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_addr  (out_addr)
   );

   // handshake completes at the following rising edge
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         spk_cnt++;
         if (out_addr != exp_addr) addr_err++;
      end
   end

   // fields: target(11) weight(3) excite(1) count(3) prob(8) expected spikes(3)
   localparam logic [28:0] VEC [16] = '{
      {11'd3,    3'd5, 1'b1, 3'd0, 8'd255, 3'd0},
      {11'd3,    3'd5, 1'b1, 3'd0, 8'd255, 3'd1},
      {11'd7,    3'd7, 1'b1, 3'd3, 8'd255, 3'd2},
      {11'd7,    3'd3, 1'b0, 3'd1, 8'd255, 3'd0},
      {11'd7,    3'd5, 1'b1, 3'd0, 8'd255, 3'd0},
      {11'd7,    3'd5, 1'b1, 3'd0, 8'd255, 3'd1},
      {11'd9,    3'd7, 1'b1, 3'd7, 8'd0,   3'd0},
      {11'd9,    3'd5, 1'b1, 3'd0, 8'd255, 3'd0},
      {11'd9,    3'd5, 1'b1, 3'd0, 8'd255, 3'd1},
      {11'd2047, 3'd7, 1'b1, 3'd1, 8'd255, 3'd1},
      {11'd0,    3'd0, 1'b1, 3'd7, 8'd255, 3'd0},
      {11'd0,    3'd2, 1'b1, 3'd4, 8'd255, 3'd1},
      {11'd5,    3'd5, 1'b1, 3'd0, 8'd255, 3'd0},
      {11'd3,    3'd1, 1'b1, 3'd0, 8'd255, 3'd0},
      {11'd5,    3'd2, 1'b0, 3'd0, 8'd255, 3'd0},
      {11'd5,    3'd7, 1'b1, 3'd0, 8'd255, 3'd1}
   };
   localparam string VREQ [16] = '{
      "R2", "R9", "R5", "R3", "R3", "R4", "R6", "R6",
      "R6", "R10", "R11", "R5", "R2", "R10", "R3", "R3"
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [10:0] t, input logic [2:0] w, input logic e,
                       input logic [2:0] c, input logic [7:0] p);
      @(negedge clk);
      in_target = t;
      in_weight = w;
      in_excite = e;
      in_count  = c;
      in_prob   = p;
      in_valid  = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!in_ready);
      repeat (8) @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
   end

   initial begin
      int clr_cycles;
      int base;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: quiet during clearing sweep
      @(negedge clk);
      check(!in_ready, "R1 in_ready during clear", int'(in_ready), 0);
      check(!out_valid, "R1 out_valid during clear", int'(out_valid), 0);
      clr_cycles = 1;
      while (!in_ready) begin
         @(negedge clk);
         clr_cycles++;
      end
      check(clr_cycles >= 2047, "R1 clear length", clr_cycles, 2048);

      // table walk, threshold 40
      threshold = 12'd40;
      for (int i = 0; i < 16; i++) begin
         exp_addr = VEC[i][28:18];
         base     = spk_cnt;
         addr_err = 0;
         send(VEC[i][28:18], VEC[i][17:15], VEC[i][14], VEC[i][13:11], VEC[i][10:3]);
         wait_idle();
         check(spk_cnt - base == int'(VEC[i][2:0]), VREQ[i], spk_cnt - base, int'(VEC[i][2:0]));
         check(addr_err == 0, VREQ[i], addr_err, 0);
      end

      // R7: raised threshold 100, neuron 11: 28,56,84 then 112 fires
      threshold = 12'd100;
      exp_addr  = 11'd11;
      base      = spk_cnt;
      send(11'd11, 3'd7, 1'b1, 3'd2, 8'd255);
      wait_idle();
      check(spk_cnt == base, "R7 below threshold", spk_cnt - base, 0);
      send(11'd11, 3'd7, 1'b1, 3'd0, 8'd255);
      wait_idle();
      check(spk_cnt - base == 1, "R7 at threshold", spk_cnt - base, 1);

      // R8: queue full stall, threshold 20 so every delivery fires
      threshold = 12'd20;
      exp_addr  = 11'd12;
      addr_err  = 0;
      @(posedge clk);
      #1 out_ready = 1'b0;
      base = spk_cnt;
      send(11'd12, 3'd5, 1'b1, 3'd7, 8'd255);
      repeat (20) @(negedge clk);
      check(!in_ready, "R8 stalled ready", int'(in_ready), 0);
      check(out_valid, "R8 spike waiting", int'(out_valid), 1);
      @(posedge clk);
      #1 out_ready = 1'b1;
      wait_idle();
      check(spk_cnt - base == 8, "R8 no spike lost", spk_cnt - base, 8);
      check(addr_err == 0, "R8 spike address", addr_err, 0);

      // R6: probability 128 on 256 attempts, every delivery fires at threshold 4
      threshold = 12'd4;
      exp_addr  = 11'd20;
      base      = spk_cnt;
      for (int k = 0; k < 32; k++) send(11'd20, 3'd1, 1'b1, 3'd7, 8'd128);
      wait_idle();
      check((spk_cnt - base >= 80) && (spk_cnt - base <= 176), "R6 delivery rate",
            spk_cnt - base, 128);

      summary();
      $finish;
   end
endmodule